// File: doc/BRIEF.md
# Live-Time Deadline Prefetch Trigger

This block keeps per-frame timekeeping for a cache and decides, for each cache frame, the moment its resident block is most likely dead, so that a prefetch can be placed into that frame. Every generation of a frame starts with a demand miss fill. At that fill the block receives the new resident tag, a predicted live time and the tag of the block expected to follow. A coarse global tick advances a small per-frame generation counter. Each hit copies that counter into a live-time register, so the register holds the time from fill to the most recent hit.

When the elapsed generation time reaches twice the predicted live time, the frame is declared dead and becomes due. A fixed-priority arbiter turns due frames into prefetch strobes, one per cycle, each carrying the frame index and the follower tag. A frame fires at most once per generation. A demand fill that arrives first cancels the pending prefetch. When a generation ends by a fill, the block reports the departing tag and its measured live time for the correlation table to learn from.

Top module: `livetime_deadpred`

## Requirements
- R1: After reset no frame is valid, and both `pf_valid_o` and `upd_valid_o` are low until stimulus makes them rise.
- R2: A fill clears the frame's generation counter. The counter then advances by one on each cycle with `tick_i` high and saturates at 31.
- R3: A hit to a valid frame copies the generation counter value from before that cycle's tick into the frame's live-time register. A hit to a frame that was never filled changes nothing.
- R4: A fill to a valid frame raises `upd_valid_o` in the next cycle, with `upd_tag_o` set to the departing tag and `upd_live_o` set to its live time. That live time is 0 when the generation had no hit. A fill to an invalid frame produces no update.
- R5: A frame is due once its generation count is at least twice its predicted live time, compared at 6 bits. In the cycle after it is granted, `pf_valid_o` is high with `pf_frame_o` set to the frame index and `pf_tag_o` set to the follower tag. A predicted live time of 16 or more never fires. A predicted live time of 0 fires in the cycle after the cycle following the fill.
- R6: A frame issues at most one prefetch per generation.
- R7: A fill to a frame in a cycle where that frame is due cancels the prefetch. The new generation starts fresh.
- R8: When several frames are due in the same cycle, the lowest index is issued first and the others follow, one per cycle.
- R9: A hit and a fill to the same frame in the same cycle act as the fill alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Global coarse time tick |
| hit_i | input | 1 | Demand hit strobe |
| hit_frame_i | input | IDX_W | Frame of the hit |
| fill_i | input | 1 | Demand miss fill strobe, starts a generation |
| fill_frame_i | input | IDX_W | Frame being filled |
| fill_tag_i | input | TAG_W | Tag of the block brought in |
| fill_pred_i | input | 5 | Predicted live time in ticks |
| fill_next_i | input | TAG_W | Tag of the predicted follower block |
| pf_valid_o | output | 1 | Prefetch issue strobe |
| pf_frame_o | output | IDX_W | Frame targeted by the prefetch |
| pf_tag_o | output | TAG_W | Tag to prefetch |
| upd_valid_o | output | 1 | Generation-end report strobe |
| upd_tag_o | output | TAG_W | Tag of the departing block |
| upd_live_o | output | 5 | Measured live time of the departing block |

## Verification
The bench builds the block with four frames and 8-bit tags. With that few frames, several frames can be driven to the same deadline on one tick, which exercises the ordering of the arbiter and the queueing of the frames it defers. The 5-bit counters stay at their default width, so about forty ticks are enough to reach the saturation point. The same ticks show that a predicted live time of 16 has an unreachable deadline.

// File: rtl/ltp_pkg.sv
package ltp_pkg;

    localparam int CNT_W = 5;
    localparam int DL_W  = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             valid;
        logic             fired;
        logic [CNT_W-1:0] gen;
        logic [CNT_W-1:0] live;
        logic [CNT_W-1:0] pred;
    } frame_timer_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

    function automatic logic [DL_W-1:0] deadline_of(input logic [CNT_W-1:0] p);
        return {p, 1'b0};
    endfunction

endpackage

// File: rtl/ltp_frame.sv
module ltp_frame
    import ltp_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             hit_i,
    input  logic             fill_i,
    input  logic [TAG_W-1:0] fill_tag_i,
    input  logic [TAG_W-1:0] fill_next_i,
    input  logic [CNT_W-1:0] fill_pred_i,
    input  logic             grant_i,
    output logic             valid_o,
    output logic             due_o,
    output logic [TAG_W-1:0] tag_o,
    output logic [TAG_W-1:0] next_o,
    output logic [CNT_W-1:0] live_o
);

    frame_timer_t     st;
    logic [TAG_W-1:0] cur_tag;
    logic [TAG_W-1:0] nxt_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            cur_tag <= '0;
            nxt_tag <= '0;
        end else if (fill_i) begin
            st.valid <= 1'b1;
            st.fired <= 1'b0;
            st.gen   <= '0;
            st.live  <= '0;
            st.pred  <= fill_pred_i;
            cur_tag  <= fill_tag_i;
            nxt_tag  <= fill_next_i;
        end else begin
            if (tick_i)
                st.gen <= sat_inc(st.gen);
            if (hit_i && st.valid)
                st.live <= st.gen;
            if (grant_i)
                st.fired <= 1'b1;
        end
    end

    // Fill in the same cycle cancels the deadline of the ending generation.
    always_comb begin
        due_o = st.valid && !st.fired && !fill_i &&
                ({1'b0, st.gen} >= deadline_of(st.pred));
    end

    assign valid_o = st.valid;
    assign tag_o   = cur_tag;
    assign next_o  = nxt_tag;
    assign live_o  = st.live;

endmodule

// File: rtl/ltp_prio_arb.sv
module ltp_prio_arb #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     grant_o,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                idx_o      = IDX_W'(i);
            end
        end
        any_o = |req_i;
    end

endmodule

// File: rtl/livetime_deadpred.sv
module livetime_deadpred
    import ltp_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int TAG_W      = 12,
    localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             hit_i,
    input  logic [IDX_W-1:0] hit_frame_i,
    input  logic             fill_i,
    input  logic [IDX_W-1:0] fill_frame_i,
    input  logic [TAG_W-1:0] fill_tag_i,
    input  logic [4:0]       fill_pred_i,
    input  logic [TAG_W-1:0] fill_next_i,
    output logic             pf_valid_o,
    output logic [IDX_W-1:0] pf_frame_o,
    output logic [TAG_W-1:0] pf_tag_o,
    output logic             upd_valid_o,
    output logic [TAG_W-1:0] upd_tag_o,
    output logic [4:0]       upd_live_o
);

    logic [NUM_FRAMES-1:0] valid_vec;
    logic [NUM_FRAMES-1:0] due_vec;
    logic [NUM_FRAMES-1:0] grant_vec;
    logic [TAG_W-1:0]      tag_arr  [NUM_FRAMES];
    logic [TAG_W-1:0]      next_arr [NUM_FRAMES];
    logic [CNT_W-1:0]      live_arr [NUM_FRAMES];
    logic                  grant_any;
    logic [IDX_W-1:0]      grant_idx;

    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
        logic hit_sel;
        logic fill_sel;
        assign hit_sel  = hit_i  && (hit_frame_i  == IDX_W'(i));
        assign fill_sel = fill_i && (fill_frame_i == IDX_W'(i));

        ltp_frame #(.TAG_W(TAG_W)) u_frame (
            .clk         (clk),
            .rst         (rst),
            .tick_i      (tick_i),
            .hit_i       (hit_sel),
            .fill_i      (fill_sel),
            .fill_tag_i  (fill_tag_i),
            .fill_next_i (fill_next_i),
            .fill_pred_i (fill_pred_i),
            .grant_i     (grant_vec[i]),
            .valid_o     (valid_vec[i]),
            .due_o       (due_vec[i]),
            .tag_o       (tag_arr[i]),
            .next_o      (next_arr[i]),
            .live_o      (live_arr[i])
        );
    end

    ltp_prio_arb #(.N(NUM_FRAMES), .IDX_W(IDX_W)) u_arb (
        .req_i   (due_vec),
        .grant_o (grant_vec),
        .any_o   (grant_any),
        .idx_o   (grant_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_valid_o  <= 1'b0;
            pf_frame_o  <= '0;
            pf_tag_o    <= '0;
            upd_valid_o <= 1'b0;
            upd_tag_o   <= '0;
            upd_live_o  <= '0;
        end else begin
            pf_valid_o  <= grant_any;
            pf_frame_o  <= grant_idx;
            pf_tag_o    <= next_arr[grant_idx];
            upd_valid_o <= fill_i && valid_vec[fill_frame_i];
            upd_tag_o   <= tag_arr[fill_frame_i];
            upd_live_o  <= live_arr[fill_frame_i];
        end
    end

endmodule

// File: rtl/ltp_checker.sv
module ltp_checker #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  fill_i,
    input logic [IDX_W-1:0]      fill_frame_i,
    input logic                  pf_valid_o,
    input logic [IDX_W-1:0]      pf_frame_o,
    input logic                  upd_valid_o,
    input logic [NUM_FRAMES-1:0] grant_vec,
    input logic [NUM_FRAMES-1:0] due_vec
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!pf_valid_o && !upd_valid_o));

    assert_update_after_fill_R4: assert property (@(posedge clk) disable iff (rst)
        upd_valid_o |-> $past(fill_i));

    assert_no_repeat_R6: assert property (@(posedge clk) disable iff (rst)
        pf_valid_o |=> !(pf_valid_o && pf_frame_o == $past(pf_frame_o)));

    assert_fill_cancels_R7: assert property (@(posedge clk) disable iff (rst)
        fill_i |=> !(pf_valid_o && pf_frame_o == $past(fill_frame_i)));

    assert_single_grant_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_vec));

    assert_grant_when_due_R8: assert property (@(posedge clk) disable iff (rst)
        (|due_vec) |=> pf_valid_o);

endmodule

bind livetime_deadpred ltp_checker #(
    .NUM_FRAMES (NUM_FRAMES),
    .IDX_W      (IDX_W)
) u_ltp_checker (
    .clk          (clk),
    .rst          (rst),
    .fill_i       (fill_i),
    .fill_frame_i (fill_frame_i),
    .pf_valid_o   (pf_valid_o),
    .pf_frame_o   (pf_frame_o),
    .upd_valid_o  (upd_valid_o),
    .grant_vec    (grant_vec),
    .due_vec      (due_vec)
);

// File: tb/livetime_deadpred_bench.sv
module livetime_deadpred_bench;

    localparam int NF = 4;
    localparam int TW = 8;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_i = 1'b0;
    logic          hit_i = 1'b0;
    logic [IW-1:0] hit_frame_i = '0;
    logic          fill_i = 1'b0;
    logic [IW-1:0] fill_frame_i = '0;
    logic [TW-1:0] fill_tag_i = '0;
    logic [4:0]    fill_pred_i = '0;
    logic [TW-1:0] fill_next_i = '0;
    logic          pf_valid_o;
    logic [IW-1:0] pf_frame_o;
    logic [TW-1:0] pf_tag_o;
    logic          upd_valid_o;
    logic [TW-1:0] upd_tag_o;
    logic [4:0]    upd_live_o;

    livetime_deadpred #(.NUM_FRAMES(NF), .TAG_W(TW)) u_livetime_deadpred (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .hit_i(hit_i), .hit_frame_i(hit_frame_i),
        .fill_i(fill_i), .fill_frame_i(fill_frame_i), .fill_tag_i(fill_tag_i),
        .fill_pred_i(fill_pred_i), .fill_next_i(fill_next_i),
        .pf_valid_o(pf_valid_o), .pf_frame_o(pf_frame_o), .pf_tag_o(pf_tag_o),
        .upd_valid_o(upd_valid_o), .upd_tag_o(upd_tag_o), .upd_live_o(upd_live_o)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad   = 0;

    // reference model state
    int m_valid [NF];
    int m_tag   [NF];
    int m_nxt   [NF];
    int m_pred  [NF];
    int m_gen   [NF];
    int m_live  [NF];
    int m_fired [NF];

    // observation log
    int pf_count [NF];
    int last_pf_tag;
    int pf_order [$];
    int upd_count;
    int last_upd_tag;
    int last_upd_live;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int e_pfv, e_pff, e_pft, e_uv, e_ut, e_ul;
        e_pfv = 0; e_pff = 0; e_pft = 0; e_uv = 0; e_ut = 0; e_ul = 0;
        if (rst) begin
            for (int i = 0; i < NF; i++) begin
                m_valid[i] = 0; m_tag[i] = 0; m_nxt[i] = 0; m_pred[i] = 0;
                m_gen[i] = 0; m_live[i] = 0; m_fired[i] = 0;
            end
        end else begin
            for (int i = 0; i < NF; i++) begin
                if (e_pfv == 0 && m_valid[i] == 1 && m_fired[i] == 0 &&
                    !(fill_i && int'(fill_frame_i) == i) && m_gen[i] >= 2 * m_pred[i]) begin
                    e_pfv = 1; e_pff = i; e_pft = m_nxt[i]; m_fired[i] = 1;
                end
            end
            if (fill_i && m_valid[fill_frame_i] == 1) begin
                e_uv = 1; e_ut = m_tag[fill_frame_i]; e_ul = m_live[fill_frame_i];
            end
            for (int i = 0; i < NF; i++) begin
                if (fill_i && int'(fill_frame_i) == i) begin
                    m_valid[i] = 1; m_tag[i] = fill_tag_i; m_nxt[i] = fill_next_i;
                    m_pred[i] = fill_pred_i; m_gen[i] = 0; m_live[i] = 0; m_fired[i] = 0;
                end else begin
                    if (hit_i && int'(hit_frame_i) == i && m_valid[i] == 1) m_live[i] = m_gen[i];
                    if (tick_i && m_gen[i] < 31) m_gen[i]++;
                end
            end
        end
        #1;
        check(int'(pf_valid_o) == e_pfv, "R5 pf_valid", pf_valid_o, e_pfv);
        if (e_pfv == 1) begin
            check(int'(pf_frame_o) == e_pff, "R8 pf_frame", pf_frame_o, e_pff);
            check(int'(pf_tag_o) == e_pft, "R5 pf_tag", pf_tag_o, e_pft);
        end
        check(int'(upd_valid_o) == e_uv, "R4 upd_valid", upd_valid_o, e_uv);
        if (e_uv == 1) begin
            check(int'(upd_tag_o) == e_ut, "R4 upd_tag", upd_tag_o, e_ut);
            check(int'(upd_live_o) == e_ul, "R3 upd_live", upd_live_o, e_ul);
        end
        if (!rst && pf_valid_o) begin
            pf_count[pf_frame_o]++;
            last_pf_tag = pf_tag_o;
            pf_order.push_back(int'(pf_frame_o));
        end
        if (!rst && upd_valid_o) begin
            upd_count++;
            last_upd_tag = upd_tag_o;
            last_upd_live = upd_live_o;
        end
    end

    task automatic step(input bit tk, input bit h, input int hf,
                        input bit f, input int ff, input int tg, input int pr, input int nx);
        @(negedge clk);
        tick_i = tk; hit_i = h; hit_frame_i = IW'(hf);
        fill_i = f; fill_frame_i = IW'(ff); fill_tag_i = TW'(tg);
        fill_pred_i = 5'(pr); fill_next_i = TW'(nx);
    endtask

    task automatic idle(input int n, input bit tk);
        for (int k = 0; k < n; k++) step(tk, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NF; i++) pf_count[i] = 0;
        upd_count = 0;
        idle(3, 1);
        @(negedge clk);
        check(pf_valid_o == 1'b0, "R1 pf idle", pf_valid_o, 0);
        check(upd_valid_o == 1'b0, "R1 upd idle", upd_valid_o, 0);
        rst = 1'b0;
        // R3: hit to never-filled frame 3, then R4: fill to invalid frame gives no update
        step(1, 1, 3, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 3, 8'h30, 31, 8'h31);
        idle(2, 0);
        check(upd_count == 0, "R4 no update on invalid frame", upd_count, 0);
        // R5: pred 2 -> deadline 4 ticks
        step(0, 0, 0, 1, 0, 8'h11, 2, 8'h22);
        idle(3, 1);
        check(pf_count[0] == 0, "R5 not yet due", pf_count[0], 0);
        idle(6, 1);
        check(pf_count[0] == 1, "R5 fired once", pf_count[0], 1);
        check(last_pf_tag == 8'h22, "R5 follower tag", last_pf_tag, 8'h22);
        idle(10, 1);
        check(pf_count[0] == 1, "R6 once per generation", pf_count[0], 1);
        // R2: pred 16 unreachable; hit after saturation reports 31
        step(0, 0, 0, 1, 1, 8'h40, 16, 8'h41);
        idle(40, 1);
        step(1, 1, 1, 0, 0, 0, 0, 0);
        idle(2, 0);
        check(pf_count[1] == 0, "R5 pred 16 never fires", pf_count[1], 0);
        step(0, 0, 0, 1, 1, 8'h50, 31, 8'h51);
        idle(2, 0);
        check(last_upd_live == 31, "R2 saturation at 31", last_upd_live, 31);
        check(last_upd_tag == 8'h40, "R4 departing tag", last_upd_tag, 8'h40);
        // R5: pred 0 fires without ticks; R4 zero live time
        step(0, 0, 0, 1, 2, 8'h60, 0, 8'h61);
        idle(3, 0);
        check(pf_count[2] == 1, "R5 pred 0 fires", pf_count[2], 1);
        step(0, 0, 0, 1, 2, 8'h70, 31, 8'h71);
        idle(2, 0);
        check(last_upd_live == 0, "R4 zero live time", last_upd_live, 0);
        // R8: frames 3 and 0 due on same tick
        pf_order.delete();
        step(0, 0, 0, 1, 3, 8'h80, 1, 8'h83);
        step(0, 0, 0, 1, 0, 8'h90, 1, 8'h93);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        idle(4, 0);
        check(pf_order.size() == 2, "R8 both issued", pf_order.size(), 2);
        if (pf_order.size() == 2) begin
            check(pf_order[0] == 0, "R8 lowest first", pf_order[0], 0);
            check(pf_order[1] == 3, "R8 deferred next", pf_order[1], 3);
        end
        // R7: refill frame 1 exactly when due
        step(0, 0, 0, 1, 1, 8'hA0, 1, 8'hA1);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 8'hB0, 31, 8'hB1);
        idle(3, 0);
        check(pf_count[1] == 0, "R7 fill cancels", pf_count[1], 0);
        // R9: hit and fill same frame same cycle
        step(1, 1, 1, 0, 0, 0, 0, 0);
        step(1, 1, 1, 1, 1, 8'hC0, 31, 8'hC1);
        idle(3, 1);
        step(0, 0, 0, 1, 1, 8'hD0, 31, 8'hD1);
        idle(2, 0);
        check(last_upd_live == 0, "R9 fill wins over hit", last_upd_live, 0);
        check(last_upd_tag == 8'hC0, "R9 new tag resident", last_upd_tag, 8'hC0);
        // random traffic, model compared every cycle
        for (int k = 0; k < 600; k++) begin
            int r;
            r = $urandom_range(0, 9);
            step($urandom_range(0, 1), r < 4, $urandom_range(0, NF - 1),
                 r == 9, $urandom_range(0, NF - 1), $urandom_range(0, 255),
                 $urandom_range(0, 17), $urandom_range(0, 255));
        end
        idle(5, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule